// File: doc/BRIEF.md
# Four-lane phase-shifted PRBS31 tap network

This block turns the 31-stage state of a PRBS31 shift register into four registered output lanes, one bit per lane per clock. Each lane carries the same maximal-length sequence. Lane k is advanced by k·E bits, where E is the inverse of four modulo 2^31−1. Because of that spacing, reading the lanes in the order lane 0, 1, 2, 3 on every cycle gives a serial stream at four times the register rate, and that stream is again a PRBS31 sequence. A 4:1 serializer that follows the block takes this stream.

Each lane is the modulo-2 sum of a fixed set of register stages. No delay line is used. The tap set for each lane is worked out during elaboration: the block raises the shift operator to the lane's delay modulo the feedback polynomial, so no hand-entered mask is needed. By default every sum is split into byte-sized partial XORs in a first register rank, and those partials are combined in a second rank. Setting `GROUP` to 0 gives a single rank instead. Every lane has the same number of ranks, so all lanes have the same latency.

The register that drives `stage_i` is expected to update as stage 1 ← stage 28 XOR stage 31, with stage n+1 ← stage n.

Top module: `prbs_quad_phase`

## Requirements
- R1: While `rst_n` is low, all bits of `lane_o` are 0. An active-low reset clears the output asynchronously.
- R2: Lane 0 (`lane_o[0]`) equals stage 1 (`stage_i[0]`) as it was presented LAT = 2 clock cycles earlier (default `GROUP` = 8).
- R3: Each lane is linear in the state. When `stage_i` is all zero, all lanes are 0. The output for a XOR b equals the output for a XOR'd with the output for b.
- R4: Drive `stage_i` from a register with the update `stage_i[0]` ← `stage_i[27]` ^ `stage_i[30]` and `stage_i[i]` ← `stage_i[i-1]`. Then the serial stream y, built per cycle as `lane_o[0]`, `lane_o[1]`, `lane_o[2]`, `lane_o[3]`, satisfies y[n] = y[n-28] ^ y[n-31] for every n.
- R5: Under the condition of R4 with a nonzero seed, the serial stream is not stuck. Over a 12,000-bit window, between 45% and 55% of its bits are 1.
- R6: All four lanes have the same latency. A state held for a single cycle between all-zero states appears on every lane in exactly cycle LAT after it is applied. In every other cycle of that window, all lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, the rate of the shift register |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_i | input | 31 | Shift-register state; bit i is stage i+1 |
| lane_o | output | 4 | Phase-shifted lanes; bit 0 is serialized first |

## Verification
Held arbitrary states, each given with a second state and with their XOR, show whether each lane is a pure parity of fixed taps and whether lane 0 is the plain stage-1 tap. A single-cycle state between zero states shows whether any lane has a latency that differs from the others. A long run driven by a true PRBS31 register, interleaved lane 0 first, is checked against the feedback recurrence. This run exposes a wrong tap set, a swapped lane order or a lane that is one cycle out of step. A bit-balance count on the same run catches a stream stuck at a constant.

// File: rtl/prbs_quad_phase.sv
module prbs_quad_phase #(
  parameter int STAGES = 31,
  parameter int FB_TAP = 28,
  parameter int LANES  = 4,
  parameter int GROUP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] stage_i,
  output logic [LANES-1:0]  lane_o
);

  localparam bit SPLIT = (GROUP > 0) && (GROUP < STAGES);
  localparam int NGRP  = SPLIT ? (STAGES + GROUP - 1) / GROUP : 1;
  localparam logic [63:0] WMASK  = (64'd1 << STAGES) - 64'd1;
  localparam logic [63:0] LOWP   = 64'd1 | (64'd1 << (STAGES - FB_TAP));
  localparam longint      PERIOD = longint'(WMASK);

  // multiply a residue by z modulo z^STAGES + z^(STAGES-FB_TAP) + 1
  function automatic logic [63:0] times_z(input logic [63:0] r);
    logic [63:0] s;
    s = (r << 1) & WMASK;
    if (r[STAGES-1]) s = s ^ LOWP;
    return s;
  endfunction

  function automatic logic [63:0] poly_mul(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] acc;
    acc = '0;
    for (int i = STAGES - 1; i >= 0; i--) begin
      acc = times_z(acc);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [63:0] z_pow(input logic [63:0] e);
    logic [63:0] r;
    r = 64'd1;
    for (int i = 63; i >= 0; i--) begin
      r = poly_mul(r, r);
      if (e[i]) r = times_z(r);
    end
    return r;
  endfunction

  function automatic longint inv_mod(input longint a, input longint m);
    longint t, nt, r, nr, q, tmp;
    t = 0; nt = 1; r = m; nr = a;
    while (nr != 0) begin
      q   = r / nr;
      tmp = t - q * nt; t = nt; nt = tmp;
      tmp = r - q * nr; r = nr; nr = tmp;
    end
    if (t < 0) t = t + m;
    return t;
  endfunction

  // lane k = b[t + k*E]; residue of z^(D+STAGES-1) gives taps, stage i <-> coeff STAGES-1-i
  function automatic logic [STAGES-1:0] lane_mask(input int k);
    longint d;
    logic [63:0] r;
    logic [STAGES-1:0] m;
    d = (longint'(k) * inv_mod(longint'(LANES), PERIOD)) % PERIOD;
    r = z_pow(64'(d) + 64'(STAGES - 1));
    for (int i = 0; i < STAGES; i++) m[i] = r[STAGES-1-i];
    return m;
  endfunction

  function automatic logic [STAGES-1:0] grp_sel(input int g);
    logic [63:0] w;
    w = ((64'd1 << GROUP) - 64'd1) << (g * GROUP);
    return w[STAGES-1:0];
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [STAGES-1:0] MASK = lane_mask(k);
    logic lane_q;

    if (SPLIT) begin : g_tree
      logic [NGRP-1:0] part_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          part_q <= '0;
          lane_q <= 1'b0;
        end else begin
          for (int g = 0; g < NGRP; g++) part_q[g] <= ^(stage_i & MASK & grp_sel(g));
          lane_q <= ^part_q;
        end
      end
    end else begin : g_flat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= 1'b0;
        else        lane_q <= ^(stage_i & MASK);
      end
    end

    assign lane_o[k] = lane_q;
  end

endmodule

// File: rtl/prbs_quad_phase_chk.sv
module prbs_quad_phase_chk #(
  parameter int STAGES = 31,
  parameter int LANES  = 4,
  parameter int GROUP  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAGES-1:0] stage_i,
  input logic [LANES-1:0]  lane_o
);

  localparam int LAT = ((GROUP > 0) && (GROUP < STAGES)) ? 2 : 1;

  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= '0;
    else if (warm != 3'd7)  warm <= warm + 3'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> lane_o == '0);

  a_r2_lane0_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'(LAT)) |-> lane_o[0] == $past(stage_i[0], LAT));

  a_r3_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'(LAT) && $past(stage_i, LAT) == '0) |-> lane_o == '0);

  a_r6_equal_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'(LAT + 1) && $past(stage_i, LAT) == $past(stage_i, LAT + 1)) |-> $stable(lane_o));

endmodule

bind prbs_quad_phase prbs_quad_phase_chk #(
  .STAGES(STAGES), .LANES(LANES), .GROUP(GROUP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stage_i(stage_i), .lane_o(lane_o)
);

// File: tb/prbs_quad_phase_test.sv
module prbs_quad_phase_test;
  localparam int LAT = 2;
  localparam int NVEC = 6;
  localparam int RUN = 3000;

  localparam logic [30:0] VEC_A [NVEC] = '{31'h0000_0001, 31'h4000_0000, 31'h2AAA_5555,
                                           31'h7FFF_FFFF, 31'h1234_5678, 31'h0F0F_00F1};
  localparam logic [30:0] VEC_B [NVEC] = '{31'h0000_0002, 31'h0800_0000, 31'h5555_AAAA,
                                           31'h0000_8000, 31'h6543_2101, 31'h70F0_FF0E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [30:0] stage_i = '0;
  logic [3:0]  lane_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prbs_quad_phase uut (.clk(clk), .rst_n(rst_n), .stage_i(stage_i), .lane_o(lane_o));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] lfsr_next(input logic [30:0] s);
    return {s[29:0], s[27] ^ s[30]};
  endfunction

  task automatic settle(input logic [30:0] v, output logic [3:0] o);
    @(negedge clk);
    stage_i = v;
    repeat (LAT + 1) @(negedge clk);
    o = lane_o;
  endtask

  task automatic pulse(input logic [30:0] v, input logic [3:0] held);
    @(negedge clk);
    stage_i = '0;
    repeat (LAT + 2) @(negedge clk);
    stage_i = v;
    for (int off = 1; off <= LAT + 2; off++) begin
      @(negedge clk);
      check(lane_o == ((off == LAT) ? held : 4'h0), "R6 single-cycle state timing",
            32'(lane_o), 32'((off == LAT) ? held : 4'h0));
      stage_i = '0;
    end
  endtask

  initial begin
    logic [3:0] oa, ob, oc;
    logic [30:0] s;
    logic [1:0]  sh;
    logic [30:0] h;
    int nbits, ones;

    stage_i = 31'h2AAA_5555;
    repeat (4) @(negedge clk);
    check(lane_o == 4'h0, "R1 outputs during reset", 32'(lane_o), 0);
    stage_i = '0;
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    check(lane_o == 4'h0, "R3 zero state after reset", 32'(lane_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      settle(VEC_A[i], oa);
      check(oa[0] == VEC_A[i][0], "R2 lane0 is stage1", 32'(oa[0]), 32'(VEC_A[i][0]));
      settle(VEC_B[i], ob);
      check(ob[0] == VEC_B[i][0], "R2 lane0 is stage1", 32'(ob[0]), 32'(VEC_B[i][0]));
      settle(VEC_A[i] ^ VEC_B[i], oc);
      check(oc == (oa ^ ob), "R3 linearity", 32'(oc), 32'(oa ^ ob));
      pulse(VEC_A[i], oa);
    end

    s = 31'h5A3C_96E1;
    sh = '0;
    h = '0;
    nbits = 0;
    ones = 0;
    for (int cyc = 0; cyc < RUN; cyc++) begin
      @(negedge clk);
      if (cyc >= LAT) begin
        check(lane_o[0] == sh[LAT-1], "R2 lane0 delay in run", 32'(lane_o[0]), 32'(sh[LAT-1]));
        for (int k = 0; k < 4; k++) begin
          if (nbits >= 31)
            check(lane_o[k] == (h[27] ^ h[30]), "R4 interleaved recurrence",
                  32'(lane_o[k]), 32'(h[27] ^ h[30]));
          h = {h[29:0], lane_o[k]};
          nbits++;
          ones += int'(lane_o[k]);
        end
      end
      sh = {sh[0], s[0]};
      stage_i = s;
      s = lfsr_next(s);
    end
    check(ones * 100 >= nbits * 45 && ones * 100 <= nbits * 55, "R5 ones balance",
          32'(ones), 32'(nbits / 2));

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(lane_o == 4'h0, "R1 asynchronous clear", 32'(lane_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule